// File: doc/BRIEF.md
# Serial Isolation Bit Responder

This block is the per-card engine that takes part in serial isolation on a shared configuration bus. While its card is in the isolation state, every read of the isolation register at the card's own read-data port is one half of a two-read exchange. Across these exchanges the engine presents the card's identifier one bit at a time. A one bit is answered by driving 0x55 on the first read of the exchange and 0xAA on the second. A zero bit leaves the bus undriven and listens instead.

When a zero-bit card hears 0x55 and then 0xAA on the bus during one exchange, another card is still competing with a one bit. The engine then reports a one-cycle loss pulse, and the card state machine moves the card to sleep. A wake write addressed to the card restarts the exchange sequence at bit 0. The bus wiring and the card state machine sit outside this block.

Top module: `iso_bit_responder`

## Requirements
- R1: After reset `drv_en` and `lost` are low, `drv_data` is 0x00, and the next qualified read is the first read of bit 0.
- R2: Identifier bit k of the stream is `card_id[k]`. Byte 0 is `card_id[7:0]` and goes first, and bits within each byte go least significant first.
- R3: On the first read of an exchange the engine drives 0x55 with `drv_en` high if the current bit is one. If the bit is zero, `drv_en` stays low and `drv_data` is 0x00. The bit index then advances.
- R4: On the second read the response of the first read is shifted left by one: a one bit drives 0xAA with `drv_en` high, and a zero bit keeps `drv_en` low with `drv_data` 0x00.
- R5: Once all ID_BITS exchanges have completed, further reads get no drive until a wake.
- R6: A read with `in_iso` low or `rd_match` low gets no drive and does not advance the exchange. The next qualified read continues where the sequence stopped.
- R7: A `wake_hit` cycle returns the engine to the first read of bit 0 and clears any listen state.
- R8: A card whose current bit is zero raises `lost` in the cycle after the second read when it observed 0x55 on `bus_obs` at the first read and 0xAA at the second read.
- R9: `lost` stays low when the card drove a one bit, when the bus read idle (0xFF), or when 0xAA is seen at the second read without 0x55 at the first.
- R10: `lost` is high for exactly one cycle for each losing exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle strobe for a read of the isolation register |
| rd_match | input | 1 | The read addresses this card's read-data port |
| in_iso | input | 1 | The card is in the isolation state |
| wake_hit | input | 1 | A wake write addressed to this card |
| card_id | input | ID_BITS | Card identifier, streamed from bit 0 upward |
| bus_obs | input | 8 | Data byte observed on the shared bus during the read |
| drv_en | output | 1 | The card drives the bus in this read cycle |
| drv_data | output | 8 | Byte driven when `drv_en` is high, otherwise 0x00 |
| lost | output | 1 | One-cycle pulse: the card lost arbitration |

## Verification
The bench builds the block with its defaults: a 72-bit identifier and the full listen mode, in which a loss needs both halves of the pattern. With these values the bench can walk the whole 72-exchange stream, reach the end-of-identifier stop, and separate a half pattern (only 0xAA) from a complete pattern. Random identifiers and random observed bus bytes drive the loss decision through every combination of bit value and bus contents.

// File: rtl/iso_resp_pkg.sv
`timescale 1ns/1ps
package iso_resp_pkg;
   localparam logic [7:0] PAT_FIRST  = 8'h55;
   localparam logic [7:0] PAT_SECOND = 8'hAA;
   localparam logic [7:0] BUS_IDLE   = 8'hFF;

   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } pair_ph_e;
endpackage

// File: rtl/iso_pair_seq.sv
`timescale 1ns/1ps
// Tracks which half of the exchange comes next and which identifier bit is current.
module iso_pair_seq
   import iso_resp_pkg::*;
#(
   parameter int ID_BITS = 72,
   parameter int IDX_W   = $clog2(ID_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   output pair_ph_e         phase,
   output logic [IDX_W-1:0] idx,
   output logic             exhausted
);
   pair_ph_e         ph_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_FIRST;
         idx_q <= '0;
      end else if (restart) begin
         ph_q  <= PH_FIRST;
         idx_q <= '0;
      end else if (step) begin
         if (ph_q == PH_FIRST) begin
            ph_q  <= PH_SECOND;
            idx_q <= idx_q + 1'b1;
         end else begin
            ph_q  <= PH_FIRST;
         end
      end
   end

   assign phase     = ph_q;
   assign idx       = idx_q;
   assign exhausted = (ph_q == PH_FIRST) && (idx_q == IDX_W'(ID_BITS));
endmodule

// File: rtl/iso_bit_pick.sv
`timescale 1ns/1ps
// Selects the current identifier bit; indices past the end read as zero.
module iso_bit_pick #(
   parameter int ID_BITS = 72,
   parameter int IDX_W   = $clog2(ID_BITS + 1)
) (
   input  logic [ID_BITS-1:0] id,
   input  logic [IDX_W-1:0]   idx,
   output logic               bit_o
);
   localparam int PAD_BITS = 2 ** IDX_W;

   logic [PAD_BITS-1:0] padded;

   always_comb begin
      padded              = '0;
      padded[ID_BITS-1:0] = id;
   end

   assign bit_o = padded[idx];
endmodule

// File: rtl/iso_bus_listen.sv
`timescale 1ns/1ps
// Listening side of a zero-bit card: decides whether another card is driving a one.
module iso_bus_listen
   import iso_resp_pkg::*;
#(
   parameter bit LISTEN_FULL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       first_rd,
   input  logic       second_rd,
   input  logic       my_bit,
   input  logic       quiet,
   input  logic [7:0] bus_obs,
   output logic       lost
);
   logic arm;
   logic lost_q;

   generate
      if (LISTEN_FULL) begin : g_full
         logic saw_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               saw_q <= 1'b0;
            else if (restart)
               saw_q <= 1'b0;
            else if (first_rd)
               saw_q <= !my_bit && (bus_obs == PAT_FIRST);
         end
         assign arm = saw_q;
      end else begin : g_echo
         assign arm = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lost_q <= 1'b0;
      else
         lost_q <= second_rd && !restart && quiet && arm && (bus_obs == PAT_SECOND);
   end

   assign lost = lost_q;
endmodule

// File: rtl/iso_bit_responder.sv
`timescale 1ns/1ps
module iso_bit_responder
   import iso_resp_pkg::*;
#(
   parameter int ID_BITS     = 72,
   parameter bit LISTEN_FULL = 1'b1,
   parameter int IDX_W       = $clog2(ID_BITS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_stb,
   input  logic               rd_match,
   input  logic               in_iso,
   input  logic               wake_hit,
   input  logic [ID_BITS-1:0] card_id,
   input  logic [7:0]         bus_obs,
   output logic               drv_en,
   output logic [7:0]         drv_data,
   output logic               lost
);
   generate
      if (ID_BITS < 1) begin : g_bad_len
         $error("iso_bit_responder: ID_BITS must be at least 1");
      end
      if (IDX_W < $clog2(ID_BITS + 1)) begin : g_bad_idx
         $error("iso_bit_responder: IDX_W too narrow for ID_BITS");
      end
   endgenerate

   pair_ph_e         phase;
   logic [IDX_W-1:0] idx;
   logic             exhausted;
   logic             cur_bit;
   logic             act;
   logic             first_rd;
   logic             second_rd;
   logic [7:0]       resp_q;
   logic [7:0]       resp_now;

   assign act       = rd_stb && in_iso && rd_match && !exhausted;
   assign first_rd  = act && (phase == PH_FIRST);
   assign second_rd = act && (phase == PH_SECOND);

   iso_pair_seq #(.ID_BITS(ID_BITS), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (wake_hit),
      .step      (act && !wake_hit),
      .phase     (phase),
      .idx       (idx),
      .exhausted (exhausted)
   );

   iso_bit_pick #(.ID_BITS(ID_BITS), .IDX_W(IDX_W)) u_pick (
      .id    (card_id),
      .idx   (idx),
      .bit_o (cur_bit)
   );

   // Response byte of the first read; the second read shifts it left by one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         resp_q <= '0;
      else if (wake_hit)
         resp_q <= '0;
      else if (first_rd)
         resp_q <= cur_bit ? PAT_FIRST : 8'h00;
   end

   always_comb begin
      if (phase == PH_FIRST)
         resp_now = cur_bit ? PAT_FIRST : 8'h00;
      else
         resp_now = {resp_q[6:0], 1'b0};
   end

   assign drv_en   = act && (resp_now != 8'h00);
   assign drv_data = drv_en ? resp_now : 8'h00;

   iso_bus_listen #(.LISTEN_FULL(LISTEN_FULL)) u_listen (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (wake_hit),
      .first_rd  (first_rd && !wake_hit),
      .second_rd (second_rd),
      .my_bit    (cur_bit),
      .quiet     (resp_q == 8'h00),
      .bus_obs   (bus_obs),
      .lost      (lost)
   );
endmodule

// File: rtl/iso_bit_responder_chk.sv
`timescale 1ns/1ps
module iso_bit_responder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_stb,
   input logic       rd_match,
   input logic       in_iso,
   input logic       wake_hit,
   input logic       card_lsb,
   input logic       drv_en,
   input logic [7:0] drv_data,
   input logic       lost
);
   assert_drive_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (rd_stb && in_iso && rd_match));

   // R4 as well: only the two fixed patterns ever reach the bus
   assert_drive_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (drv_data == 8'h55 || drv_data == 8'hAA));

   assert_lost_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lost |-> $past(rd_stb && in_iso && rd_match));

   assert_no_lost_if_drove_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lost |-> !$past(drv_en));

   assert_lost_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> !lost);

   assert_wake_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wake_hit) && !wake_hit && rd_stb && in_iso && rd_match)
      |-> (drv_en == card_lsb));
endmodule

bind iso_bit_responder iso_bit_responder_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_stb   (rd_stb),
   .rd_match (rd_match),
   .in_iso   (in_iso),
   .wake_hit (wake_hit),
   .card_lsb (card_id[0]),
   .drv_en   (drv_en),
   .drv_data (drv_data),
   .lost     (lost)
);

// File: tb/iso_bit_responder_tb.sv
`timescale 1ns/1ps
module iso_bit_responder_tb;
   localparam int N = 72;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rd_stb = 1'b0;
   logic         rd_match = 1'b0;
   logic         in_iso = 1'b0;
   logic         wake_hit = 1'b0;
   logic [N-1:0] card_id = '0;
   logic [7:0]   bus_obs = 8'hFF;
   logic         drv_en;
   logic [7:0]   drv_data;
   logic         lost;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // bench model of the exchange state
   int  m_idx = 0;
   bit  m_ph = 1'b0;
   bit  m_bit = 1'b0;
   bit  m_saw = 1'b0;

   always #4 clk = ~clk;

   iso_bit_responder #(.ID_BITS(N), .LISTEN_FULL(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_match(rd_match),
      .in_iso(in_iso), .wake_hit(wake_hit), .card_id(card_id),
      .bus_obs(bus_obs), .drv_en(drv_en), .drv_data(drv_data), .lost(lost)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_first(input bit b);
      return b ? 8'h55 : 8'h00;
   endfunction

   function automatic bit exp_loss(input bit b, input bit saw, input logic [7:0] bus);
      return !b && saw && (bus == 8'hAA);
   endfunction

   // One read strobe; checks the drive in the read cycle and lost one cycle later.
   task automatic do_rd(input logic [7:0] bus, input bit iso, input bit hit,
                        input string rq_first);
      bit          qual;
      bit          e_en;
      logic [7:0]  e_dat;
      bit          e_lost;
      string       rq;
      @(negedge clk);
      rd_stb = 1'b1; bus_obs = bus; in_iso = iso; rd_match = hit;
      qual   = iso && hit && !(m_ph == 1'b0 && m_idx == N);
      e_lost = 1'b0;
      if (!qual) begin
         e_en = 1'b0; e_dat = 8'h00;
         rq = (m_idx == N && m_ph == 1'b0 && iso && hit) ? "R5" : "R6";
      end else if (m_ph == 1'b0) begin
         m_bit = card_id[m_idx];
         e_en  = m_bit; e_dat = exp_first(m_bit);
         m_saw = !m_bit && (bus == 8'h55);
         m_idx++; m_ph = 1'b1;
         rq = rq_first;
      end else begin
         e_en   = m_bit; e_dat = m_bit ? 8'hAA : 8'h00;
         e_lost = exp_loss(m_bit, m_saw, bus);
         m_ph   = 1'b0;
         rq = "R4";
      end
      #1;
      chk(rq, "drv_en", 32'(drv_en), 32'(e_en));
      chk(rq, "drv_data", 32'(drv_data), 32'(e_dat));
      @(negedge clk);
      rd_stb = 1'b0; bus_obs = 8'hFF;
      chk(e_lost ? "R8" : "R9", "lost", 32'(lost), 32'(e_lost));
      if (e_lost) begin
         @(negedge clk);
         chk("R10", "lost second cycle", 32'(lost), 32'd0);
      end
   endtask

   task automatic do_wake();
      @(negedge clk);
      wake_hit = 1'b1;
      @(negedge clk);
      wake_hit = 1'b0;
      m_idx = 0; m_ph = 1'b0; m_bit = 1'b0; m_saw = 1'b0;
   endtask

   function automatic logic [7:0] rand_bus();
      case ($urandom % 4)
         0: return 8'hFF;
         1: return 8'h55;
         2: return 8'hAA;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240503));
      card_id = {8'hC3, 64'h0123_4567_89AB_CDEF};
      repeat (3) @(negedge clk);
      chk("R1", "drv_en in reset", 32'(drv_en), 32'd0);
      chk("R1", "lost in reset", 32'(lost), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "drv_data after reset", 32'(drv_data), 32'd0);
      chk("R1", "lost after reset", 32'(lost), 32'd0);
      in_iso = 1'b1; rd_match = 1'b1;

      // R2: whole identifier with an idle bus, bit 0 of byte 0 first
      for (int k = 0; k < N; k++) begin
         do_rd(8'hFF, 1'b1, 1'b1, "R2");
         do_rd(8'hFF, 1'b1, 1'b1, "R2");
      end
      // R5: stream exhausted
      do_rd(8'h55, 1'b1, 1'b1, "R5");
      do_rd(8'hAA, 1'b1, 1'b1, "R5");

      // R7: wake restarts at bit 0
      do_wake();
      do_rd(8'hFF, 1'b1, 1'b1, "R7");
      do_rd(8'hFF, 1'b1, 1'b1, "R7");
      // R6: unqualified reads are ignored, sequence resumes at bit 1
      do_rd(8'h55, 1'b0, 1'b1, "R6");
      do_rd(8'h55, 1'b1, 1'b0, "R6");
      do_rd(8'hFF, 1'b1, 1'b1, "R6");
      do_rd(8'hFF, 1'b1, 1'b1, "R6");

      // R8 / R9 / R10 directed: bit0=0, bit1=1, bit2=0, bit3=0
      card_id = {68'h0, 4'b0010};
      do_wake();
      do_rd(8'h55, 1'b1, 1'b1, "R8");
      do_rd(8'hAA, 1'b1, 1'b1, "R8");   // loses
      do_rd(8'h55, 1'b1, 1'b1, "R9");   // own one bit
      do_rd(8'hAA, 1'b1, 1'b1, "R9");
      do_rd(8'hFF, 1'b1, 1'b1, "R9");   // half pattern only
      do_rd(8'hAA, 1'b1, 1'b1, "R9");
      do_rd(8'hFF, 1'b1, 1'b1, "R9");   // idle bus
      do_rd(8'hFF, 1'b1, 1'b1, "R9");

      // random identifiers, bus bytes and gating
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < N; k++) card_id[k] = 1'($urandom);
         do_wake();
         for (int k = 0; k < 2 * N + 4; k++) begin
            bit g_iso = ($urandom % 10) != 0;
            bit g_hit = ($urandom % 10) != 0;
            do_rd(rand_bus(), g_iso, g_hit, "R3");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule